// File: doc/BRIEF.md
# Dual Byte Mailbox Between Master Controller and Video Processor

This block passes single bytes in both directions between a master controller and a slave video processor. For the outbound direction the slave loads a byte into an outbound latch and raises a data-ready flag. The master polls a status byte. It then takes the byte by turning on the data drivers. That read sets an interrupt toward the slave, and the slave's handler drops data-ready. For the inbound direction the master strobes a byte into an inbound latch. The strobe sets a second interrupt toward the slave, whose handler marks the port busy. Once the slave has taken the byte, it drops busy again.

The master has no read path of its own. It shares a return bus with its switch scan and enables either the data drivers or the status drivers in step with that scan. Both status flags and both interrupts are held in small two-state machines, with states FLAG_CLEAR and FLAG_HELD. A flag moves FLAG_CLEAR→FLAG_HELD on its set event and FLAG_HELD→FLAG_CLEAR on its clear event. When both events occur in the same cycle, the set wins. The return-bus selector picks one of RET_OFF, RET_DATA and RET_STAT in each cycle.

The slave sees four registers selected by `slv_addr`:
- 0: writing loads the outbound latch, and reading returns the inbound latch.
- 1: the status flags.
- 2: the interrupt flags. Reading returns the pending bits. Writing a 1 to a bit acknowledges that interrupt.
- 3: unused.

Top module: `mbx_dual_mailbox`

## Requirements
- R1: After reset both latches hold 0, both status flags and both interrupts are low, and `ret_bus` is 0.
- R2: A slave write with `slv_addr`=0 loads `slv_wdata` into the outbound latch. While `mst_data_en` is high, `ret_bus` carries that latch in the same cycle.
- R3: The status byte has data-ready in bit 0 and port-busy in bit 1, and all other bits are 0. A slave write with `slv_addr`=1 sets data-ready to `slv_wdata[0]` and port-busy to `slv_wdata[1]`. The status byte can be read by the slave at `slv_addr`=1, and it appears on `ret_bus` while only `mst_stat_en` is high.
- R4: While neither enable is high, `ret_bus` is 0.
- R5: While both enables are high, `ret_bus` carries the outbound latch.
- R6: A rising edge of `mst_data_en` sets `slv_irq_taken` from the next cycle on. Holding `mst_data_en` high does not set it again, and `mst_stat_en` never sets it.
- R7: A cycle with `mst_wr` high captures `mst_wdata` into the inbound latch, which the slave reads at `slv_addr`=0. It also sets `slv_irq_arrived` from the next cycle on.
- R8: Each interrupt stays high until a slave write with `slv_addr`=2 has a 1 in its bit. Bit 0 acknowledges `slv_irq_taken` and bit 1 acknowledges `slv_irq_arrived`. The other interrupt is unaffected. A slave read at `slv_addr`=2 returns {`slv_irq_arrived`, `slv_irq_taken`} in bits 1:0.
- R9: If an interrupt's set event and its acknowledge fall in the same cycle, the interrupt is high afterwards.
- R10: Master reads and writes never change the status flags. Only slave writes with `slv_addr`=1 do.
- R11: A slave read at `slv_addr`=3 returns 0, and slave writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slv_we | input | 1 | Slave write strobe |
| slv_addr | input | 2 | Slave register select |
| slv_wdata | input | DATA_W | Slave write data |
| slv_rdata | output | DATA_W | Slave read data (combinational on address) |
| slv_irq_taken | output | 1 | Interrupt: master has read the outbound latch |
| slv_irq_arrived | output | 1 | Interrupt: master has written the inbound latch |
| mst_wr | input | 1 | Master write strobe to the inbound latch |
| mst_wdata | input | DATA_W | Master write data |
| mst_data_en | input | 1 | Master enable of the data drivers |
| mst_stat_en | input | 1 | Master enable of the status drivers |
| ret_bus | output | DATA_W | Shared return bus to the master |

## Verification
Some rules are checked by assertions on every cycle:
- the idle and data-priority values of the return bus;
- agreement between the status on the bus and the slave's status readback;
- interrupt set-on-event and hold-until-acknowledge;
- status stability when no status write occurs.

Other behaviour needs the bench's scenarios, because it depends on sequences:
- one interrupt per data-enable edge while the enable is held;
- set winning over a same-cycle acknowledge;
- master traffic leaving the status untouched;
- writes to the unused register having no effect.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_HELD  = 1'b1
    } flag_state_e;

    typedef enum logic [1:0] {
        RET_OFF  = 2'd0,
        RET_DATA = 2'd1,
        RET_STAT = 2'd2
    } ret_sel_e;

    localparam logic [1:0] REG_MAIL   = 2'd0;
    localparam logic [1:0] REG_STATUS = 2'd1;
    localparam logic [1:0] REG_IRQ    = 2'd2;
    localparam logic [1:0] REG_SPARE  = 2'd3;

    localparam int NUM_FLAGS  = 4;
    localparam int FL_READY   = 0;
    localparam int FL_BUSY    = 1;
    localparam int FL_TAKEN   = 2;
    localparam int FL_ARRIVED = 3;

endpackage

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set_i) state_d = FLAG_HELD;
            FLAG_HELD:  if (clr_i && !set_i) state_d = FLAG_CLEAR;
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLAG_HELD);
    end

endmodule

// File: rtl/mbx_slave_regs.sv
module mbx_slave_regs
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slv_we,
    input  logic [1:0]        slv_addr,
    input  logic [DATA_W-1:0] slv_wdata,
    input  logic              mst_wr,
    input  logic [DATA_W-1:0] mst_wdata,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [DATA_W-1:0] ob_q,
    output logic [DATA_W-1:0] ib_q,
    output logic [DATA_W-1:0] status_word,
    output logic              stat_wr,
    output logic              irq_ack_wr,
    output logic [DATA_W-1:0] slv_rdata
);

    logic [DATA_W-1:0] irq_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ob_q <= '0;
            ib_q <= '0;
        end else begin
            if (slv_we && slv_addr == REG_MAIL) ob_q <= slv_wdata;
            if (mst_wr)                         ib_q <= mst_wdata;
        end
    end

    always_comb begin
        stat_wr     = slv_we && (slv_addr == REG_STATUS);
        irq_ack_wr  = slv_we && (slv_addr == REG_IRQ);
        status_word = '0;
        status_word[0] = flags[FL_READY];
        status_word[1] = flags[FL_BUSY];
        irq_word    = '0;
        irq_word[0] = flags[FL_TAKEN];
        irq_word[1] = flags[FL_ARRIVED];
    end

    always_comb begin
        slv_rdata = '0;
        unique case (slv_addr)
            REG_MAIL:   slv_rdata = ib_q;
            REG_STATUS: slv_rdata = status_word;
            REG_IRQ:    slv_rdata = irq_word;
            REG_SPARE:  slv_rdata = '0;
            default:    slv_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbx_ret_mux.sv
module mbx_ret_mux
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              data_en,
    input  logic              stat_en,
    input  logic [DATA_W-1:0] ob_q,
    input  logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] ret_bus
);

    ret_sel_e sel;

    always_comb begin
        if (data_en)      sel = RET_DATA;
        else if (stat_en) sel = RET_STAT;
        else              sel = RET_OFF;
    end

    always_comb begin
        ret_bus = '0;
        unique case (sel)
            RET_OFF:  ret_bus = '0;
            RET_DATA: ret_bus = ob_q;
            RET_STAT: ret_bus = status_word;
            default:  ret_bus = '0;
        endcase
    end

endmodule

// File: rtl/mbx_dual_mailbox.sv
module mbx_dual_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slv_we,
    input  logic [1:0]        slv_addr,
    input  logic [DATA_W-1:0] slv_wdata,
    output logic [DATA_W-1:0] slv_rdata,
    output logic              slv_irq_taken,
    output logic              slv_irq_arrived,
    input  logic              mst_wr,
    input  logic [DATA_W-1:0] mst_wdata,
    input  logic              mst_data_en,
    input  logic              mst_stat_en,
    output logic [DATA_W-1:0] ret_bus
);

    logic [DATA_W-1:0]    ob_q;
    logic [DATA_W-1:0]    ib_q;
    logic [DATA_W-1:0]    status_word;
    logic                 stat_wr;
    logic                 irq_ack_wr;
    logic                 data_en_q;
    logic                 rd_event;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;

    // edge detector: one read event per rising edge of the data enable
    always_ff @(posedge clk) begin
        if (!rst_n) data_en_q <= 1'b0;
        else        data_en_q <= mst_data_en;
    end

    always_comb begin
        rd_event             = mst_data_en && !data_en_q;
        flag_set[FL_READY]   = stat_wr &&  slv_wdata[0];
        flag_clr[FL_READY]   = stat_wr && !slv_wdata[0];
        flag_set[FL_BUSY]    = stat_wr &&  slv_wdata[1];
        flag_clr[FL_BUSY]    = stat_wr && !slv_wdata[1];
        flag_set[FL_TAKEN]   = rd_event;
        flag_clr[FL_TAKEN]   = irq_ack_wr && slv_wdata[0];
        flag_set[FL_ARRIVED] = mst_wr;
        flag_clr[FL_ARRIVED] = irq_ack_wr && slv_wdata[1];
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        mbx_flag_fsm u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .clr_i  (flag_clr[g]),
            .flag_o (flag_q[g])
        );
    end

    mbx_slave_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .slv_we      (slv_we),
        .slv_addr    (slv_addr),
        .slv_wdata   (slv_wdata),
        .mst_wr      (mst_wr),
        .mst_wdata   (mst_wdata),
        .flags       (flag_q),
        .ob_q        (ob_q),
        .ib_q        (ib_q),
        .status_word (status_word),
        .stat_wr     (stat_wr),
        .irq_ack_wr  (irq_ack_wr),
        .slv_rdata   (slv_rdata)
    );

    mbx_ret_mux #(.DATA_W(DATA_W)) u_ret (
        .data_en     (mst_data_en),
        .stat_en     (mst_stat_en),
        .ob_q        (ob_q),
        .status_word (status_word),
        .ret_bus     (ret_bus)
    );

    always_comb begin
        slv_irq_taken   = flag_q[FL_TAKEN];
        slv_irq_arrived = flag_q[FL_ARRIVED];
    end

endmodule

// File: rtl/mbx_dual_mailbox_chk.sv
module mbx_dual_mailbox_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slv_we,
    input logic [1:0]        slv_addr,
    input logic [DATA_W-1:0] slv_wdata,
    input logic [DATA_W-1:0] slv_rdata,
    input logic              slv_irq_taken,
    input logic              slv_irq_arrived,
    input logic              mst_wr,
    input logic [DATA_W-1:0] mst_wdata,
    input logic              mst_data_en,
    input logic              mst_stat_en,
    input logic [DATA_W-1:0] ret_bus,
    input logic [DATA_W-1:0] ob_q,
    input logic [DATA_W-1:0] ib_q,
    input logic [DATA_W-1:0] status_word
);

    a_r4_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst_data_en && !mst_stat_en) |-> (ret_bus == '0));

    a_r5_data_priority: assert property (@(posedge clk) disable iff (!rst_n)
        mst_data_en |-> (ret_bus == ob_q));

    a_r3_status_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_stat_en && !mst_data_en && slv_addr == 2'd1) |-> (ret_bus == slv_rdata));

    a_r6_read_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_data_en) |=> slv_irq_taken);

    a_r7_inbound_capture: assert property (@(posedge clk) disable iff (!rst_n)
        mst_wr |=> (slv_irq_arrived && ib_q == $past(mst_wdata)));

    a_r8_taken_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_irq_taken && !(slv_we && slv_addr == 2'd2 && slv_wdata[0])) |=> slv_irq_taken);

    a_r8_arrived_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_irq_arrived && !(slv_we && slv_addr == 2'd2 && slv_wdata[1])) |=> slv_irq_arrived);

    a_r10_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(slv_we && slv_addr == 2'd1) |=> $stable(status_word));

endmodule

bind mbx_dual_mailbox mbx_dual_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .slv_we          (slv_we),
    .slv_addr        (slv_addr),
    .slv_wdata       (slv_wdata),
    .slv_rdata       (slv_rdata),
    .slv_irq_taken   (slv_irq_taken),
    .slv_irq_arrived (slv_irq_arrived),
    .mst_wr          (mst_wr),
    .mst_wdata       (mst_wdata),
    .mst_data_en     (mst_data_en),
    .mst_stat_en     (mst_stat_en),
    .ret_bus         (ret_bus),
    .ob_q            (ob_q),
    .ib_q            (ib_q),
    .status_word     (status_word)
);

// File: tb/sim_mbx_dual_mailbox.sv
module sim_mbx_dual_mailbox;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slv_we = 1'b0;
    logic [1:0] slv_addr = 2'd0;
    logic [7:0] slv_wdata = 8'h00;
    logic [7:0] slv_rdata;
    logic       slv_irq_taken;
    logic       slv_irq_arrived;
    logic       mst_wr = 1'b0;
    logic [7:0] mst_wdata = 8'h00;
    logic       mst_data_en = 1'b0;
    logic       mst_stat_en = 1'b0;
    logic [7:0] ret_bus;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0] m_ob = 0, m_ib = 0;
    bit m_ready = 0, m_busy = 0, m_taken = 0, m_arrived = 0, m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_dual_mailbox #(.DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .slv_we(slv_we), .slv_addr(slv_addr), .slv_wdata(slv_wdata),
        .slv_rdata(slv_rdata), .slv_irq_taken(slv_irq_taken),
        .slv_irq_arrived(slv_irq_arrived),
        .mst_wr(mst_wr), .mst_wdata(mst_wdata),
        .mst_data_en(mst_data_en), .mst_stat_en(mst_stat_en),
        .ret_bus(ret_bus)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {6'b0, m_busy, m_ready};
    endfunction

    function automatic logic [7:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return m_ib;
            2'd1:    return m_status();
            2'd2:    return {6'b0, m_arrived, m_taken};
            default: return 8'h00;
        endcase
    endfunction

    task automatic step(input bit we, input logic [1:0] a, input logic [7:0] wd,
                        input bit mw, input logic [7:0] md, input bit de, input bit se);
        logic [7:0] exp_bus;
        string tag;
        bit rise;
        @(negedge clk);
        slv_we = we; slv_addr = a; slv_wdata = wd;
        mst_wr = mw; mst_wdata = md; mst_data_en = de; mst_stat_en = se;
        #1;
        if (de)      begin exp_bus = m_ob;       tag = se ? "R5" : "R2"; end
        else if (se) begin exp_bus = m_status(); tag = "R3"; end
        else         begin exp_bus = 8'h00;      tag = "R4"; end
        chk(ret_bus == exp_bus, tag, ret_bus, exp_bus);
        chk(slv_rdata == m_rdata(a), (a == 2'd3) ? "R11" : "R8", slv_rdata, m_rdata(a));
        chk(slv_irq_taken == m_taken, "R6", slv_irq_taken, m_taken);
        chk(slv_irq_arrived == m_arrived, "R7", slv_irq_arrived, m_arrived);
        rise = de && !m_prev;
        @(posedge clk);
        #1;
        if (we && a == 2'd0) m_ob = wd;
        if (we && a == 2'd1) begin m_ready = wd[0]; m_busy = wd[1]; end
        if (mw) m_ib = md;
        if (rise) m_taken = 1;
        else if (we && a == 2'd2 && wd[0]) m_taken = 0;
        if (mw) m_arrived = 1;
        else if (we && a == 2'd2 && wd[1]) m_arrived = 0;
        m_prev = de;
    endtask

    task automatic idle(input logic [1:0] a);
        step(0, a, 8'h00, 0, 8'h00, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        chk(ret_bus == 8'h00, "R1", ret_bus, 0);
        chk(slv_rdata == 8'h00, "R1", slv_rdata, 0);
        chk(!slv_irq_taken && !slv_irq_arrived, "R1", {slv_irq_arrived, slv_irq_taken}, 0);
        idle(2'd1);

        // R2/R3: outbound byte and data-ready
        step(1, 2'd0, 8'hA5, 0, 8'h00, 0, 0);
        step(1, 2'd1, 8'h01, 0, 8'h00, 0, 0);
        step(0, 2'd1, 8'h00, 0, 8'h00, 0, 1);
        chk(ret_bus == 8'h01, "R3", ret_bus, 8'h01);
        // R6: read raises taken
        step(0, 2'd2, 8'h00, 0, 8'h00, 1, 0);
        chk(slv_irq_taken == 1, "R6", slv_irq_taken, 1);
        chk(ret_bus == 8'hA5, "R2", ret_bus, 8'hA5);
        step(0, 2'd2, 8'h00, 0, 8'h00, 1, 0);
        step(1, 2'd2, 8'h01, 0, 8'h00, 1, 0);
        chk(slv_irq_taken == 0, "R8", slv_irq_taken, 0);
        step(0, 2'd2, 8'h00, 0, 8'h00, 1, 0);
        chk(slv_irq_taken == 0, "R6", slv_irq_taken, 0);
        step(0, 2'd2, 8'h00, 0, 8'h00, 0, 1);
        chk(slv_irq_taken == 0, "R6", slv_irq_taken, 0);

        // R7: inbound byte
        step(0, 2'd0, 8'h00, 1, 8'h3C, 0, 0);
        chk(slv_irq_arrived == 1, "R7", slv_irq_arrived, 1);
        chk(slv_rdata == 8'h3C, "R7", slv_rdata, 8'h3C);
        step(1, 2'd1, 8'h03, 0, 8'h00, 0, 0);
        step(1, 2'd2, 8'h01, 0, 8'h00, 0, 0);
        chk(slv_irq_arrived == 1, "R8", slv_irq_arrived, 1);
        step(1, 2'd2, 8'h02, 0, 8'h00, 0, 0);
        chk(slv_irq_arrived == 0, "R8", slv_irq_arrived, 0);

        // R5: both enables
        step(0, 2'd1, 8'h00, 0, 8'h00, 1, 1);
        chk(ret_bus == 8'hA5, "R5", ret_bus, 8'hA5);
        step(1, 2'd2, 8'h01, 0, 8'h00, 0, 0);

        // R9: set and acknowledge in one cycle
        step(1, 2'd2, 8'h01, 0, 8'h00, 1, 0);
        chk(slv_irq_taken == 1, "R9", slv_irq_taken, 1);
        step(1, 2'd2, 8'h01, 0, 8'h00, 0, 0);
        step(1, 2'd2, 8'h02, 1, 8'h77, 0, 0);
        chk(slv_irq_arrived == 1, "R9", slv_irq_arrived, 1);
        step(1, 2'd2, 8'h03, 0, 8'h00, 0, 0);

        // R10: master traffic leaves status alone
        step(0, 2'd1, 8'h00, 1, 8'h11, 0, 0);
        step(0, 2'd1, 8'h00, 0, 8'h00, 1, 0);
        step(0, 2'd1, 8'h00, 1, 8'h22, 0, 1);
        chk(slv_rdata == 8'h03, "R10", slv_rdata, 8'h03);
        chk(ret_bus == 8'h03, "R10", ret_bus, 8'h03);
        step(1, 2'd2, 8'h03, 0, 8'h00, 0, 0);

        // R11: spare register
        step(1, 2'd3, 8'hFF, 0, 8'h00, 0, 0);
        step(0, 2'd3, 8'h00, 0, 8'h00, 0, 0);
        chk(slv_rdata == 8'h00, "R11", slv_rdata, 0);
        step(0, 2'd1, 8'h00, 0, 8'h00, 1, 0);
        chk(ret_bus == 8'hA5 && slv_rdata == 8'h03, "R11", {ret_bus, slv_rdata}, 16'hA503);
        chk(slv_irq_taken == 1, "R6", slv_irq_taken, 1);

        // mixed traffic against the reference model
        for (int i = 0; i < 120; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + 11) ^ (i >> 2));
            step(v[0], 2'(v[2:1]), 8'(v * 3), v[3] & v[5], 8'(v + 8'h5A), v[4], v[6]);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule